// File: doc/BRIEF.md
# Memory-Mapped Register Window to Legacy Display Port Bridge

This block is a bus slave that owns a 4 KiB memory-mapped register window and forwards accesses that fall into two sub-windows onto two back-end register interfaces. The first back end is a byte-wide legacy display port bus. A sub-window of 32 bytes maps linearly onto port numbers 0x3C0 to 0x3DF. The second back end is an indexed file of eleven 16-bit extended display registers, reached through an index port and a data port. It has its own 22-byte sub-window, in which each register sits at twice its index.

The bus side uses a valid/ready handshake and accepts 1-, 2- and 4-byte reads and writes. The bridge cuts each access into back-end cycles in a fixed ascending order and issues them one per clock. It merges read bytes little-endian into a 32-bit response, then raises ready for a single cycle. Because multi-byte legacy writes go out low byte first, software can load an index register and the data register beside it with one word write. A byte write to the extended file becomes a read-modify-write, so the other byte lane of the register keeps its value.

Top module: `mmioPortBridge`

## Requirements
- R1: While and after reset, busReady, portValid and extSel are low and busRdata is zero.
- R2: An access starting at window offset 0x400+k (0 <= k < 0x20) produces legacy port cycles whose port number is 0x3C0+k for its first byte.
- R3: A multi-byte legacy write sends byte 0 of busWdata (bits 7:0) to port P in the first port cycle, and then byte j to port P+j in each following consecutive cycle.
- R4: A legacy read returns the byte from port P+j in busRdata bits 8j+7:8j, and zeros in the byte lanes it did not read.
- R5: busSize encodes the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. A legacy access issues one port cycle per byte, for 1, 2 or 4 cycles.
- R6: An extended access at offset 0x500+k writes index k>>1 to the index port (extIsData=0, extWrite=1, extWdata=index). In the very next cycle it performs the data-port operation.
- R7: A 4-byte extended access performs two index/data pairs, index i first and then i+1. Register i maps to busRdata/busWdata bits 15:0 and register i+1 maps to bits 31:16. A 2-byte access uses bits 15:0 only.
- R8: A 1-byte extended write reads the register and then writes it back. Only byte lane k[0] changes, to busWdata[7:0].
- R9: A 1-byte extended read returns byte lane k[0] of the register in busRdata[7:0] and zeros above it.
- R10: An access that starts outside both sub-windows produces no back-end cycle, reads as zero, and completes.
- R11: busReady rises for exactly one cycle after the last back-end cycle. Counting from the accept cycle, it comes after n+1 cycles, where n is: the byte count for legacy; 2 for extended 1-byte reads, 2-byte accesses and all reads of width 1 or 2; 3 for extended 1-byte writes; 4 for extended 4-byte accesses; and 1 for accesses outside both sub-windows.
- R12: The bridge issues no cycle for a byte that runs past offset 0x41F, or for a register index of 11 or more. Such bytes read as zero and writes to them are dropped. The cycle count of R11 does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Request valid; held until busReady |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | Access width code (0:1 B, 1:2 B, 2:4 B) |
| busAddr | input | 12 | Byte offset inside the window |
| busWdata | input | 32 | Write data, little-endian |
| busReady | output | 1 | One-cycle completion pulse |
| busRdata | output | 32 | Read data, valid with busReady |
| portValid | output | 1 | Legacy port cycle strobe |
| portWrite | output | 1 | Legacy port cycle is a write |
| portNum | output | 10 | Legacy port number |
| portWdata | output | 8 | Legacy port write byte |
| portRdata | input | 8 | Legacy port read byte, same cycle |
| extSel | output | 1 | Extended register cycle strobe |
| extIsData | output | 1 | 0 = index port, 1 = data port |
| extWrite | output | 1 | Extended cycle is a write |
| extWdata | output | 16 | Index value or register write data |
| extRdata | input | 16 | Data port read value, same cycle |

## Verification
A wrong sequencer state shows up on the back-end pins in the cycle it happens. Examples are a skipped or repeated port number, a data-port cycle with no index write just before it, or a strobe with no request. It also shows at the end of the transfer, as a ready pulse that arrives off the fixed latency or lasts longer than one cycle. A wrong byte-lane or merge choice in the datapath appears in the write data of the offending cycle. It also shows in busRdata of the next readback of the same offset. That is why every offset of both sub-windows is written and then read back at every width.

// File: rtl/mmio_bridge_pkg.sv
package mmio_bridge_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_LEG  = 2'd1,
    RGN_EXT  = 2'd2
  } region_e;

  // Strobes from the sequencer to the datapath for the current cycle.
  typedef struct packed {
    logic       load;     // latch a new request
    logic       portCyc;  // issue a legacy port cycle
    logic [1:0] lane;     // byte lane of the legacy cycle
    logic       extCyc;   // issue an extended register cycle
    logic       extData;  // 0: index port, 1: data port
    logic       extRmw;   // data write carries merged byte
    logic       word;     // 16-bit word of a 4-byte access
    logic       wr;       // cycle direction
    logic       capture;  // take back-end read data this cycle
    logic       done;     // completion pulse
  } ctrl_s;

  localparam logic [1:0] SIZE_B1 = 2'd0;
  localparam logic [1:0] SIZE_B2 = 2'd1;

endpackage

// File: rtl/bridgeDatapath.sv
module bridgeDatapath
  import mmio_bridge_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LEG_BASE  = 'h400,
  parameter int LEG_SPAN  = 'h20,
  parameter int EXT_BASE  = 'h500,
  parameter int EXT_REGS  = 11,
  parameter int PORT_BASE = 'h3C0,
  parameter int PORT_W    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  input  ctrl_s             ctl,
  output region_e           region,
  output logic [3:0]        laneOk,
  output logic [1:0]        wordOk,
  output logic [1:0]        reqSize,
  output logic              reqWrite,
  output logic [31:0]       busRdata,
  output logic [PORT_W-1:0] portNum,
  output logic [7:0]        portWdata,
  input  logic [7:0]        portRdata,
  output logic [15:0]       extWdata,
  input  logic [15:0]       extRdata
);

  localparam int LEG_END = LEG_BASE + LEG_SPAN;
  localparam int EXT_END = EXT_BASE + 2 * EXT_REGS;

  logic [ADDR_W-1:0] reqAddr;
  logic [31:0]       reqWdata;
  logic [31:0]       rdataReg;
  logic [15:0]       rmwReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqSize  <= '0;
      reqWrite <= 1'b0;
      reqWdata <= '0;
      rdataReg <= '0;
      rmwReg   <= '0;
    end else if (ctl.load) begin
      reqAddr  <= busAddr;
      reqSize  <= busSize;
      reqWrite <= busWrite;
      reqWdata <= busWdata;
      rdataReg <= '0;
    end else if (ctl.capture) begin
      if (ctl.portCyc) begin
        rdataReg[{ctl.lane, 3'b000} +: 8] <= portRdata;
      end else if (ctl.extCyc) begin
        rmwReg <= extRdata;
        if (!reqWrite) begin
          if (reqSize == SIZE_B1)
            rdataReg <= {24'd0, reqAddr[0] ? extRdata[15:8] : extRdata[7:0]};
          else
            rdataReg[{ctl.word, 4'b0000} +: 16] <= extRdata;
        end
      end
    end
  end

  assign busRdata = rdataReg;

  // Region decode on the latched start address.
  always_comb begin
    region = RGN_NONE;
    if (int'(reqAddr) >= LEG_BASE && int'(reqAddr) < LEG_END)      region = RGN_LEG;
    else if (int'(reqAddr) >= EXT_BASE && int'(reqAddr) < EXT_END) region = RGN_EXT;
  end

  // Per-byte legacy decode.
  logic [ADDR_W:0] laneAddr [4];
  for (genvar k = 0; k < 4; k++) begin : gLane
    assign laneAddr[k] = {1'b0, reqAddr} + (ADDR_W+1)'(k);
    assign laneOk[k]   = (int'(laneAddr[k]) < LEG_END);
  end

  // Per-word extended decode.
  logic [ADDR_W-1:0] extOff;
  logic [ADDR_W-1:0] wordIdx [2];
  assign extOff = reqAddr - ADDR_W'(EXT_BASE);
  for (genvar w = 0; w < 2; w++) begin : gWord
    assign wordIdx[w] = (extOff >> 1) + ADDR_W'(w);
    assign wordOk[w]  = (int'(wordIdx[w]) < EXT_REGS);
  end

  logic [ADDR_W:0] legOff;
  assign legOff    = laneAddr[ctl.lane] - (ADDR_W+1)'(LEG_BASE);
  assign portNum   = PORT_W'(PORT_BASE) + PORT_W'(legOff);
  assign portWdata = reqWdata[{ctl.lane, 3'b000} +: 8];

  always_comb begin
    if (!ctl.extData)
      extWdata = 16'(wordIdx[ctl.word]);
    else if (ctl.extRmw)
      extWdata = reqAddr[0] ? {reqWdata[7:0], rmwReg[7:0]} : {rmwReg[15:8], reqWdata[7:0]};
    else
      extWdata = reqWdata[{ctl.word, 4'b0000} +: 16];
  end

endmodule

// File: rtl/bridgeControl.sv
module bridgeControl
  import mmio_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busValid,
  input  region_e    region,
  input  logic [3:0] laneOk,
  input  logic [1:0] wordOk,
  input  logic [1:0] reqSize,
  input  logic       reqWrite,
  output ctrl_s      ctl
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  state_e     state, stateNxt;
  logic [1:0] beat, beatNxt;
  logic [1:0] phase, phaseNxt;
  logic [1:0] lastByte;
  logic [1:0] lastWord;
  logic       rmw;
  logic       wordHit;

  assign lastByte = (reqSize == SIZE_B1) ? 2'd0 : (reqSize == SIZE_B2) ? 2'd1 : 2'd3;
  assign lastWord = (reqSize == SIZE_B1 || reqSize == SIZE_B2) ? 2'd0 : 2'd1;
  assign rmw      = reqWrite && (reqSize == SIZE_B1);
  assign wordHit  = wordOk[beat[0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      beat  <= '0;
      phase <= '0;
    end else begin
      state <= stateNxt;
      beat  <= beatNxt;
      phase <= phaseNxt;
    end
  end

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    beatNxt  = beat;
    phaseNxt = phase;
    unique case (state)
      ST_IDLE: begin
        beatNxt  = '0;
        phaseNxt = '0;
        if (busValid) begin
          ctl.load = 1'b1;
          stateNxt = ST_RUN;
        end
      end
      ST_RUN: begin
        unique case (region)
          RGN_LEG: begin
            ctl.lane    = beat;
            ctl.portCyc = laneOk[beat];
            ctl.wr      = reqWrite;
            ctl.capture = laneOk[beat] && !reqWrite;
            if (beat == lastByte) stateNxt = ST_DONE;
            else                  beatNxt  = beat + 2'd1;
          end
          RGN_EXT: begin
            logic lastPhase;
            ctl.word   = beat[0];
            ctl.extCyc = wordHit;
            lastPhase  = 1'b0;
            case (phase)
              2'd0: begin
                ctl.extData = 1'b0;
                ctl.wr      = 1'b1;
              end
              2'd1: begin
                ctl.extData = 1'b1;
                ctl.wr      = reqWrite && !rmw;
                ctl.capture = wordHit && !ctl.wr;
                lastPhase   = !rmw;
              end
              default: begin
                ctl.extData = 1'b1;
                ctl.wr      = 1'b1;
                ctl.extRmw  = 1'b1;
                lastPhase   = 1'b1;
              end
            endcase
            if (!lastPhase) begin
              phaseNxt = phase + 2'd1;
            end else if (beat == lastWord) begin
              stateNxt = ST_DONE;
            end else begin
              beatNxt  = beat + 2'd1;
              phaseNxt = '0;
            end
          end
          default: stateNxt = ST_DONE;
        endcase
      end
      default: begin
        ctl.done = 1'b1;
        stateNxt = ST_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/mmioPortBridge.sv
module mmioPortBridge
  import mmio_bridge_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LEG_BASE  = 'h400,
  parameter int LEG_SPAN  = 'h20,
  parameter int EXT_BASE  = 'h500,
  parameter int EXT_REGS  = 11,
  parameter int PORT_BASE = 'h3C0,
  parameter int PORT_W    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              busReady,
  output logic [31:0]       busRdata,
  output logic              portValid,
  output logic              portWrite,
  output logic [PORT_W-1:0] portNum,
  output logic [7:0]        portWdata,
  input  logic [7:0]        portRdata,
  output logic              extSel,
  output logic              extIsData,
  output logic              extWrite,
  output logic [15:0]       extWdata,
  input  logic [15:0]       extRdata
);

  ctrl_s      ctl;
  region_e    region;
  logic [3:0] laneOk;
  logic [1:0] wordOk;
  logic [1:0] reqSize;
  logic       reqWrite;

  bridgeControl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .region   (region),
    .laneOk   (laneOk),
    .wordOk   (wordOk),
    .reqSize  (reqSize),
    .reqWrite (reqWrite),
    .ctl      (ctl)
  );

  bridgeDatapath #(
    .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .LEG_SPAN(LEG_SPAN),
    .EXT_BASE(EXT_BASE), .EXT_REGS(EXT_REGS),
    .PORT_BASE(PORT_BASE), .PORT_W(PORT_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busSize   (busSize),
    .busWrite  (busWrite),
    .busWdata  (busWdata),
    .ctl       (ctl),
    .region    (region),
    .laneOk    (laneOk),
    .wordOk    (wordOk),
    .reqSize   (reqSize),
    .reqWrite  (reqWrite),
    .busRdata  (busRdata),
    .portNum   (portNum),
    .portWdata (portWdata),
    .portRdata (portRdata),
    .extWdata  (extWdata),
    .extRdata  (extRdata)
  );

  assign busReady  = ctl.done;
  assign portValid = ctl.portCyc;
  assign portWrite = ctl.portCyc && ctl.wr;
  assign extSel    = ctl.extCyc;
  assign extIsData = ctl.extCyc && ctl.extData;
  assign extWrite  = ctl.extCyc && ctl.wr;

endmodule

// File: rtl/bridgeChecker.sv
module bridgeChecker #(
  parameter int PORT_BASE = 'h3C0,
  parameter int PORT_W    = 10,
  parameter int LEG_SPAN  = 'h20,
  parameter int EXT_REGS  = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busReady,
  input logic [31:0]       busRdata,
  input logic              portValid,
  input logic [PORT_W-1:0] portNum,
  input logic              extSel,
  input logic              extIsData,
  input logic              extWrite,
  input logic [15:0]       extWdata
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !busReady && !portValid && !extSel && busRdata == 32'd0); // R1

  AST_PORT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    portValid |-> (int'(portNum) >= PORT_BASE && int'(portNum) < PORT_BASE + LEG_SPAN)); // R2

  AST_PORT_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    portValid && $past(portValid) |-> portNum == PORT_W'($past(portNum) + 1'b1)); // R3

  AST_INDEX_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    extIsData |-> $past(extSel)); // R6

  AST_INDEX_WRITE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    extSel && !extIsData |-> extWrite && int'(extWdata) < EXT_REGS); // R12

  AST_ONE_BACKEND: assert property (@(posedge clk) disable iff (!rstN)
    !(portValid && extSel)); // R10

  AST_NO_ORPHAN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (portValid || extSel) |-> busValid); // R10

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady); // R11

  AST_READY_AFTER_BACKEND: assert property (@(posedge clk) disable iff (!rstN)
    busReady |-> !portValid && !extSel); // R11

endmodule

bind mmioPortBridge bridgeChecker #(
  .PORT_BASE(PORT_BASE), .PORT_W(PORT_W), .LEG_SPAN(LEG_SPAN), .EXT_REGS(EXT_REGS)
) uChk (.*);

// File: tb/tb_mmioPortBridge.sv
module tb_mmioPortBridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busSize = 2'd0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busReady;
  logic [31:0] busRdata;
  logic        portValid, portWrite;
  logic [9:0]  portNum;
  logic [7:0]  portWdata, portRdata;
  logic        extSel, extIsData, extWrite;
  logic [15:0] extWdata, extRdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mmioPortBridge dut (.*);

  // Back-end models.
  logic [7:0]  portMem [32];
  logic [15:0] extMem [11];
  logic [3:0]  idxLatch;
  int          portCnt, extCnt;
  logic [9:0]  pLogNum [16];
  logic [7:0]  pLogDat [16];
  logic        eLogData [16];
  logic        eLogWr [16];
  logic [15:0] eLogDat [16];

  always_comb begin
    portRdata = (portNum >= 10'h3C0 && portNum < 10'h3E0) ? portMem[5'(portNum - 10'h3C0)] : 8'hEE;
    extRdata  = (idxLatch < 4'd11) ? extMem[idxLatch] : 16'hDEAD;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) portMem[i] <= 8'(i * 7 + 3);
      for (int i = 0; i < 11; i++) extMem[i] <= 16'(i * 'h1111) ^ 16'h0F0F;
      idxLatch <= '0;
      portCnt  <= 0;
      extCnt   <= 0;
    end else begin
      if (portValid) begin
        pLogNum[portCnt % 16] <= portNum;
        pLogDat[portCnt % 16] <= portWdata;
        portCnt <= portCnt + 1;
        if (portWrite && portNum >= 10'h3C0 && portNum < 10'h3E0)
          portMem[5'(portNum - 10'h3C0)] <= portWdata;
      end
      if (extSel) begin
        eLogData[extCnt % 16] <= extIsData;
        eLogWr[extCnt % 16]   <= extWrite;
        eLogDat[extCnt % 16]  <= extWdata;
        extCnt <= extCnt + 1;
        if (!extIsData && extWrite) idxLatch <= extWdata[3:0];
        else if (extIsData && extWrite && idxLatch < 4'd11) extMem[idxLatch] <= extWdata;
      end
    end
  end

  // Bench shadows computed from the requirements.
  logic [7:0]  expLeg [32];
  logic [15:0] expExt [11];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doTxn(input bit wr, input logic [1:0] sz, input logic [11:0] addr,
                       input logic [31:0] wd, output logic [31:0] rd, output int cyc,
                       output int p0, output int e0);
    @(negedge clk);
    p0 = portCnt;
    e0 = extCnt;
    busWrite = wr; busSize = sz; busAddr = addr; busWdata = wd; busValid = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!busReady && cyc < 50);
    rd = busRdata;
    busValid = 1'b0;
  endtask

  function automatic int nBytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int cyc, p0, e0;
    for (int i = 0; i < 32; i++) expLeg[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 11; i++) expExt[i] = 16'(i * 'h1111) ^ 16'h0F0F;
    repeat (4) @(negedge clk);
    chk("R1 ready", {31'd0, busReady}, 0);
    chk("R1 strobes", {30'd0, portValid, extSel}, 0);
    chk("R1 rdata", busRdata, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {29'd0, busReady, portValid, extSel}, 0);

    // Legacy sub-window sweep.
    for (int off = 0; off < 32; off++) begin
      for (int s = 0; s < 3; s++) begin
        logic [1:0] sz;
        logic [31:0] wd, expRd;
        int n, inWin;
        sz = 2'(s);
        n = nBytes(sz);
        inWin = (32 - off < n) ? 32 - off : n;
        wd = {8'(off + 'h40), 8'(s * 'h11 + 1), 8'(off ^ 'hA5), 8'(off * 3 + s)};
        doTxn(1'b1, sz, 12'('h400 + off), wd, rd, cyc, p0, e0);
        chk("R11 legacy write latency", cyc, n + 1);
        chk("R12 legacy write cycle count", portCnt - p0, inWin);
        chk("R10 no ext cycle on legacy", extCnt - e0, 0);
        chk("R2 first port number", {22'd0, pLogNum[p0 % 16]}, 'h3C0 + off);
        for (int j = 0; j < inWin; j++) begin
          chk("R3 port order", {22'd0, pLogNum[(p0 + j) % 16]}, 'h3C0 + off + j);
          chk("R3 R5 byte order", {24'd0, pLogDat[(p0 + j) % 16]}, {24'd0, wd[8*j +: 8]});
          expLeg[off + j] = wd[8*j +: 8];
        end
        expRd = '0;
        for (int j = 0; j < inWin; j++) expRd[8*j +: 8] = expLeg[off + j];
        doTxn(1'b0, sz, 12'('h400 + off), 32'd0, rd, cyc, p0, e0);
        chk("R4 legacy read merge", rd, expRd);
        chk("R11 legacy read latency", cyc, n + 1);
        chk("R5 legacy read cycle count", portCnt - p0, inWin);
      end
    end

    // Extended sub-window sweep.
    for (int off = 0; off < 22; off++) begin
      for (int s = 0; s < 3; s++) begin
        logic [1:0] sz;
        logic [31:0] wd, expRd;
        int idx, okWords, expCyc;
        sz = 2'(s);
        idx = off >> 1;
        okWords = (s == 2 && idx + 1 >= 11) ? 1 : (s == 2) ? 2 : 1;
        wd = {16'(off * 'h0123 + s), 16'(off * 'h3210 ^ 'h5A5A)};
        doTxn(1'b1, sz, 12'('h500 + off), wd, rd, cyc, p0, e0);
        expCyc = (s == 0) ? 3 : (s == 1) ? 2 : 4;
        chk("R11 ext write latency", cyc, expCyc + 1);
        chk("R6 index port first", {29'd0, eLogData[e0 % 16], eLogWr[e0 % 16], 1'b0}, 32'b010);
        chk("R6 index value", {16'd0, eLogDat[e0 % 16]}, idx);
        chk("R6 data follows index", {31'd0, eLogData[(e0 + 1) % 16]}, 1);
        chk("R12 ext write cycle count", extCnt - e0, okWords * ((s == 0) ? 3 : 2));
        chk("R10 no port cycle on ext", portCnt - p0, 0);
        if (s == 0) begin
          chk("R8 rmw read then write", {30'd0, eLogWr[(e0 + 1) % 16], eLogWr[(e0 + 2) % 16]}, 32'b01);
          expExt[idx][8*(off % 2) +: 8] = wd[7:0];
        end else if (s == 1) begin
          expExt[idx] = wd[15:0];
        end else begin
          expExt[idx] = wd[15:0];
          if (idx + 1 < 11) begin
            expExt[idx + 1] = wd[31:16];
            chk("R7 second index value", {16'd0, eLogDat[(e0 + 2) % 16]}, idx + 1);
          end
        end
        doTxn(1'b0, sz, 12'('h500 + off), 32'd0, rd, cyc, p0, e0);
        if (s == 0) expRd = {24'd0, expExt[idx][8*(off % 2) +: 8]};
        else if (s == 1) expRd = {16'd0, expExt[idx]};
        else expRd = {(idx + 1 < 11) ? expExt[idx + 1] : 16'd0, expExt[idx]};
        if (s == 0) chk("R9 ext byte read", rd, expRd);
        else chk("R7 ext word read", rd, expRd);
        chk("R11 ext read latency", cyc, ((s == 2) ? 4 : 2) + 1);
        // Full register readback checks the untouched lane of R8.
        doTxn(1'b0, 2'd1, 12'('h500 + 2 * idx), 32'd0, rd, cyc, p0, e0);
        chk("R8 other lane preserved", rd, {16'd0, expExt[idx]});
      end
    end

    // Outside both sub-windows.
    for (int a = 0; a < 8; a++) begin
      logic [11:0] addr;
      case (a)
        0: addr = 12'h000; 1: addr = 12'h3FF; 2: addr = 12'h420; 3: addr = 12'h4FF;
        4: addr = 12'h516; 5: addr = 12'h517; 6: addr = 12'h800; default: addr = 12'hFFC;
      endcase
      doTxn(1'b1, 2'd2, addr, 32'hFFFF_FFFF, rd, cyc, p0, e0);
      chk("R10 outside write no cycle", (portCnt - p0) + (extCnt - e0), 0);
      chk("R11 outside latency", cyc, 2);
      doTxn(1'b0, 2'd2, addr, 32'd0, rd, cyc, p0, e0);
      chk("R10 outside read zero", rd, 0);
      chk("R10 outside read no cycle", (portCnt - p0) + (extCnt - e0), 0);
    end

    // Outside writes must not have touched any register.
    for (int off = 0; off < 32; off += 4) begin
      logic [31:0] expRd;
      doTxn(1'b0, 2'd2, 12'('h400 + off), 32'd0, rd, cyc, p0, e0);
      expRd = {expLeg[off + 3], expLeg[off + 2], expLeg[off + 1], expLeg[off]};
      chk("R10 legacy file intact", rd, expRd);
    end

    @(negedge clk);
    chk("R11 ready single pulse", {31'd0, busReady}, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule